// File: doc/BRIEF.md
# Blitter Command Decoder with Rectangle Fill and Copy

This block sits behind a command queue and consumes 32-bit accelerator command words. Each word carries an opcode in its top byte and an operand below it. Parameter-load commands set up an operation: destination and source byte addresses, rectangle width and height (each stored as count minus one), and a fill colour. A separate launch command then starts either a solid rectangle fill or a rectangle copy inside a frame buffer of 16-bit RGB565 pixels.

While an operation runs, the block drives a simple request/grant memory port. A fill writes one pixel per granted cycle. A copy reads each source pixel and then writes it to the matching destination pixel. Rows are separated by a fixed line stride of `LINE_PIXELS * 2` bytes. The block takes a new command from the queue only when it is idle. When an operation finishes it sets a sticky completion flag, and that flag drives an interrupt output through an enable input.

Top module: `blit_engine`

## Requirements
- R1: The opcode is bits 31:24 of the command word. 0x0C loads the destination address and 0x0D loads the source address. 0x0E loads width-1 from bits 9:0, 0x0F loads height-1 from bits 9:0, and 0x0B loads the colour from bits 15:0. All other operand bits are discarded.
- R2: A loaded address keeps bits 23:1 of the operand and forces bit 0 to zero, so every memory access is halfword aligned.
- R3: Opcode 0x23 fills every pixel at `dst + y*LINE_PIXELS*2 + x*2`, for x in 0..width-1 and y in 0..height-1, with the colour. No other location is written.
- R4: Opcode 0x21 reads each pixel at `src + y*LINE_PIXELS*2 + x*2` and then writes that value to the same offset from `dst`.
- R5: Pixels are visited left to right within a row, and rows top to bottom. Each granted cycle completes one access. While `mem_gnt` is low, the request, address and direction hold steady.
- R6: `busy` rises in the cycle after a launch is popped and falls when the last write is granted. With the grant held high, a fill keeps `busy` high for (w+1)(h+1) cycles and a copy for twice that. `cmd_pop` is asserted only while idle.
- R7: Completion sets `irq_status`. A pulse on `irq_clr` clears it, but a completion in the same cycle wins. `irq` equals `irq_status` AND `irq_en`.
- R8: An opcode not listed in R1 or R3/R4 is popped and has no effect: no register changes and no operation starts.
- R9: A launch word with nonzero operand bits starts the same operation as one whose operand is zero.
- R10: After reset, `busy`, `mem_req`, `irq_status` and `irq` are low, and all loaded registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Queue holds a command word |
| cmd_word | input | 32 | Command word at the queue head |
| cmd_pop | output | 1 | Head word consumed this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Byte address, bit 0 zero |
| mem_wdata | output | 16 | Pixel to write |
| mem_rdata | input | 16 | Read pixel, valid in the granted cycle |
| mem_gnt | input | 1 | Access completes at this clock edge |
| busy | output | 1 | Operation in progress |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Clear completion flag |
| irq_status | output | 1 | Sticky completion flag |
| irq | output | 1 | Gated interrupt |

## Verification
Some properties are checked on every cycle:
- `cmd_pop` never occurs while busy.
- Every request address is even.
- A stalled request holds its address and direction.
- The interrupt never rises without its enable.
- The fall of `busy` is always accompanied by a set completion flag.
- A popped launch makes the block busy.

Other behaviour only the bench scenarios can show: that the right pixels get the right values, the visiting order, the exact cycle counts, the operand masking, and that unknown opcodes and launch flag bits have no effect. The bench shows these by comparing a full memory model and a log of write addresses.

// File: rtl/blit_pkg.sv
package blit_pkg;
    localparam int ADDR_W = 24;
    localparam int DIM_W  = 10;
    localparam int PIX_W  = 16;

    localparam logic [7:0] OP_COLOUR  = 8'h0B;
    localparam logic [7:0] OP_DST     = 8'h0C;
    localparam logic [7:0] OP_SRC     = 8'h0D;
    localparam logic [7:0] OP_WIDTH   = 8'h0E;
    localparam logic [7:0] OP_HEIGHT  = 8'h0F;
    localparam logic [7:0] OP_GO_COPY = 8'h21;
    localparam logic [7:0] OP_GO_FILL = 8'h23;

    typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_READ, ST_WRITE} blit_state_e;
    typedef enum logic [1:0] {GO_NONE, GO_FILL, GO_COPY} launch_e;

    typedef struct packed {
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] src;
        logic [DIM_W-1:0]  wid_m1;
        logic [DIM_W-1:0]  hgt_m1;
        logic [PIX_W-1:0]  colour;
    } blit_regs_t;

    function automatic logic [ADDR_W-1:0] even_addr(input logic [31:0] w);
        return {w[ADDR_W-1:1], 1'b0};
    endfunction
endpackage

// File: rtl/blit_cmd_decode.sv
module blit_cmd_decode
    import blit_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        accept,
    input  logic [31:0] word,
    output blit_regs_t  regs,
    output launch_e     launch
);
    logic [7:0] opc;
    assign opc = word[31:24];

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (accept) begin
            case (opc)
                OP_DST:    regs.dst    <= even_addr(word);
                OP_SRC:    regs.src    <= even_addr(word);
                OP_WIDTH:  regs.wid_m1 <= word[DIM_W-1:0];
                OP_HEIGHT: regs.hgt_m1 <= word[DIM_W-1:0];
                OP_COLOUR: regs.colour <= word[PIX_W-1:0];
                default:   ;
            endcase
        end
    end

    always_comb begin
        launch = GO_NONE;
        if (accept) begin
            if (opc == OP_GO_FILL)      launch = GO_FILL;
            else if (opc == OP_GO_COPY) launch = GO_COPY;
        end
    end
endmodule

// File: rtl/blit_walker.sv
module blit_walker
    import blit_pkg::*;
#(
    parameter int LINE_PIXELS = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              step,
    input  blit_regs_t        regs,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [ADDR_W-1:0] src_addr,
    output logic              last
);
    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(LINE_PIXELS * 2);

    logic [DIM_W-1:0]  x_q, y_q;
    logic [ADDR_W-1:0] drow_q, srow_q;
    logic [ADDR_W-1:0] xoff;

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q    <= '0;
            y_q    <= '0;
            drow_q <= '0;
            srow_q <= '0;
        end else if (start) begin
            x_q    <= '0;
            y_q    <= '0;
            drow_q <= regs.dst;
            srow_q <= regs.src;
        end else if (step) begin
            if (x_q == regs.wid_m1) begin
                x_q    <= '0;
                y_q    <= y_q + 1'b1;
                drow_q <= drow_q + STRIDE;
                srow_q <= srow_q + STRIDE;
            end else begin
                x_q <= x_q + 1'b1;
            end
        end
    end

    assign xoff     = ADDR_W'({x_q, 1'b0});
    assign dst_addr = drow_q + xoff;
    assign src_addr = srow_q + xoff;
    assign last     = (x_q == regs.wid_m1) && (y_q == regs.hgt_m1);
endmodule

// File: rtl/blit_irq.sv
module blit_irq (
    input  logic clk,
    input  logic rst,
    input  logic done,
    input  logic clr,
    input  logic en,
    output logic status,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)       status <= 1'b0;
        else if (done) status <= 1'b1;
        else if (clr)  status <= 1'b0;
    end
    assign irq = status & en;
endmodule

// File: rtl/blit_engine.sv
module blit_engine
    import blit_pkg::*;
#(
    parameter int LINE_PIXELS = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [31:0]       cmd_word,
    output logic              cmd_pop,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [PIX_W-1:0]  mem_wdata,
    input  logic [PIX_W-1:0]  mem_rdata,
    input  logic              mem_gnt,
    output logic              busy,
    input  logic              irq_en,
    input  logic              irq_clr,
    output logic              irq_status,
    output logic              irq
);
    blit_state_e       state_q;
    blit_regs_t        regs;
    launch_e           launch;
    logic [ADDR_W-1:0] dst_addr, src_addr;
    logic              last, step, done;
    logic [PIX_W-1:0]  hold_q;

    assign cmd_pop = cmd_valid && (state_q == ST_IDLE);

    blit_cmd_decode u_dec (
        .clk(clk), .rst(rst), .accept(cmd_pop), .word(cmd_word),
        .regs(regs), .launch(launch)
    );

    assign step = mem_gnt && ((state_q == ST_FILL) || (state_q == ST_WRITE));
    assign done = step && last;

    blit_walker #(.LINE_PIXELS(LINE_PIXELS)) u_walk (
        .clk(clk), .rst(rst), .start(launch != GO_NONE), .step(step),
        .regs(regs), .dst_addr(dst_addr), .src_addr(src_addr), .last(last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            hold_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (launch == GO_FILL)      state_q <= ST_FILL;
                    else if (launch == GO_COPY) state_q <= ST_READ;
                end
                ST_FILL:  if (done) state_q <= ST_IDLE;
                ST_READ: begin
                    if (mem_gnt) begin
                        hold_q  <= mem_rdata;
                        state_q <= ST_WRITE;
                    end
                end
                ST_WRITE: if (mem_gnt) state_q <= last ? ST_IDLE : ST_READ;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign mem_req   = busy;
    assign mem_we    = (state_q == ST_FILL) || (state_q == ST_WRITE);
    assign mem_addr  = (state_q == ST_READ) ? src_addr : dst_addr;
    assign mem_wdata = (state_q == ST_FILL) ? regs.colour : hold_q;

    blit_irq u_irq (
        .clk(clk), .rst(rst), .done(done), .clr(irq_clr), .en(irq_en),
        .status(irq_status), .irq(irq)
    );
endmodule

// File: rtl/blit_engine_chk.sv
module blit_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        cmd_pop,
    input logic [31:0] cmd_word,
    input logic        mem_req,
    input logic        mem_we,
    input logic [23:0] mem_addr,
    input logic        mem_gnt,
    input logic        busy,
    input logic        irq_en,
    input logic        irq_status,
    input logic        irq
);
    p_pop_idle_r6: assert property (@(posedge clk) disable iff (rst)
        cmd_pop |-> !busy);

    p_launch_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_pop && (cmd_word[31:24] == 8'h23 || cmd_word[31:24] == 8'h21)) |=> busy);

    p_even_addr_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[0] == 1'b0));

    p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_irq_gate_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (irq_en && irq_status));

    p_done_flag_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> irq_status);
endmodule

bind blit_engine blit_engine_chk u_chk (
    .clk(clk), .rst(rst), .cmd_pop(cmd_pop), .cmd_word(cmd_word),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .busy(busy), .irq_en(irq_en), .irq_status(irq_status), .irq(irq)
);

// File: tb/test_blit_engine.sv
module test_blit_engine;
    localparam int CLK_PERIOD = 10;
    localparam int STRIDE = 128;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_word = '0;
    logic        cmd_pop;
    logic        mem_req, mem_we;
    logic [23:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic        mem_gnt;
    logic        busy;
    logic        irq_en = 1'b0;
    logic        irq_clr = 1'b0;
    logic        irq_status, irq;
    logic        gnt_toggle_mode = 1'b0;
    logic        tog_q;

    int checks = 0;
    int fails  = 0;

    logic [15:0] mem   [0:4095];
    logic [15:0] model [0:4095];
    logic [23:0] wlog  [0:2047];
    int          wcnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    blit_engine i_blit_engine (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .cmd_pop(cmd_pop), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_gnt(mem_gnt), .busy(busy), .irq_en(irq_en), .irq_clr(irq_clr),
        .irq_status(irq_status), .irq(irq)
    );

    assign mem_gnt   = gnt_toggle_mode ? tog_q : 1'b1;
    assign mem_rdata = mem[mem_addr[12:1]];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4096; i++) mem[i] <= 16'(i) ^ 16'h5A00;
            wcnt  <= 0;
            tog_q <= 1'b0;
        end else begin
            tog_q <= ~tog_q;
            if (mem_req && mem_gnt && mem_we) begin
                mem[mem_addr[12:1]] <= mem_wdata;
                if (wcnt < 2048) wlog[wcnt] <= mem_addr;
                wcnt <= wcnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        #1;
        while (!cmd_pop) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
    endtask

    task automatic run_count(output int cyc);
        cyc = 0;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (!busy) break;
            cyc++;
        end
    endtask

    task automatic model_fill(input int dst, input int w, input int h, input logic [15:0] c);
        for (int y = 0; y < h; y++)
            for (int x = 0; x < w; x++)
                model[(dst + y*STRIDE + x*2) / 2] = c;
    endtask

    task automatic model_copy(input int src, input int dst, input int w, input int h);
        for (int y = 0; y < h; y++)
            for (int x = 0; x < w; x++)
                model[(dst + y*STRIDE + x*2) / 2] = model[(src + y*STRIDE + x*2) / 2];
    endtask

    task automatic cmp_mem(input string req);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < 4096; i++)
            if (mem[i] !== model[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        chk(bad == 0, req, "memory mismatches (first idx)", first, -1);
    endtask

    task automatic t_reset;
        for (int i = 0; i < 4096; i++) model[i] = 16'(i) ^ 16'h5A00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0, "R10", "busy after reset", busy, 0);
        chk(mem_req == 0, "R10", "mem_req after reset", mem_req, 0);
        chk(irq_status == 0 && irq == 0, "R10", "irq after reset", irq_status, 0);
    endtask

    task automatic t_fill_basic;
        int cyc, s;
        irq_en = 1'b1;
        send(32'h0C000200);
        send(32'h0E000003);
        send(32'h0F000002);
        send(32'h0B00A5A5);
        s = wcnt;
        send(32'h23000000);
        run_count(cyc);
        model_fill(32'h200, 4, 3, 16'hA5A5);
        chk(cyc == 12, "R6", "fill busy cycles", cyc, 12);
        chk(wcnt - s == 12, "R3", "fill write count", wcnt - s, 12);
        cmp_mem("R3");
        for (int i = 0; i < 12; i++) begin
            int exp = 32'h200 + (i / 4) * STRIDE + (i % 4) * 2;
            if (wlog[s+i] != 24'(exp)) begin
                chk(0, "R5", "write order address", wlog[s+i], exp);
                break;
            end
            if (i == 11) chk(1, "R5", "write order", 0, 0);
        end
        chk(irq_status == 1 && irq == 1, "R7", "irq after fill", irq, 1);
    endtask

    task automatic t_fill_stall;
        int cyc, s;
        gnt_toggle_mode = 1'b1;
        send(32'h0C000800);
        send(32'h0E000001);
        send(32'h0F000001);
        send(32'h0B000F0F);
        s = wcnt;
        send(32'h23000000);
        run_count(cyc);
        gnt_toggle_mode = 1'b0;
        model_fill(32'h800, 2, 2, 16'h0F0F);
        cmp_mem("R5");
        chk(cyc >= 7, "R5", "stalled fill takes longer", cyc, 7);
        chk(wlog[s+2] == 24'h880, "R5", "third write starts row 1", wlog[s+2], 24'h880);
    endtask

    task automatic t_copy;
        int cyc;
        send(32'h0D001000);
        send(32'h0C001800);
        send(32'h0E000002);
        send(32'h0F000001);
        send(32'h21000000);
        run_count(cyc);
        model_copy(32'h1000, 32'h1800, 3, 2);
        chk(cyc == 12, "R6", "copy busy cycles", cyc, 12);
        cmp_mem("R4");
    endtask

    task automatic t_masks;
        int cyc, s;
        send(32'h0C000403);
        send(32'h0E00FC01);
        send(32'h0F00FC00);
        send(32'h0BFF1234);
        s = wcnt;
        send(32'h23000000);
        run_count(cyc);
        model_fill(32'h402, 2, 1, 16'h1234);
        chk(wlog[s] == 24'h402, "R2", "first address forced even", wlog[s], 24'h402);
        chk(wcnt - s == 2, "R1", "masked width/height write count", wcnt - s, 2);
        cmp_mem("R1");
    endtask

    task automatic t_unknown;
        int cyc, s;
        send(32'h30001111);
        send(32'h0A00BEEF);
        @(negedge clk);
        chk(busy == 0, "R8", "unknown opcode starts nothing", busy, 0);
        s = wcnt;
        send(32'h23000000);
        run_count(cyc);
        model_fill(32'h402, 2, 1, 16'h1234);
        chk(wcnt - s == 2 && wlog[s] == 24'h402, "R8", "registers unchanged by unknown", wlog[s], 24'h402);
        cmp_mem("R8");
    endtask

    task automatic t_flags;
        int cyc;
        send(32'h0C000C00);
        send(32'h0B007E1F);
        send(32'h2300FFFF);
        run_count(cyc);
        model_fill(32'hC00, 2, 1, 16'h7E1F);
        chk(cyc == 2, "R9", "flagged launch cycles", cyc, 2);
        cmp_mem("R9");
    endtask

    task automatic t_irq;
        irq_en = 1'b0;
        @(negedge clk);
        chk(irq_status == 1 && irq == 0, "R7", "irq gated by enable", irq, 0);
        irq_en = 1'b1;
        #1;
        chk(irq == 1, "R7", "irq with enable", irq, 1);
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk(irq_status == 0 && irq == 0, "R7", "status cleared", irq_status, 0);
    endtask

    initial begin
        t_reset;
        t_fill_basic;
        t_fill_stall;
        t_copy;
        t_masks;
        t_unknown;
        t_flags;
        t_irq;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule